// File: doc/BRIEF.md
# Remote-Control Input Conditioner

This block is the first stage of a remote-control pulse receiver channel. It picks one of several external input pins, which may be the pin that belongs to a neighbouring channel. It can invert the picked level. It can then pass the level through a stability filter before handing a clean internal signal to a later pulse-width measurement stage. Raw pins first cross into the system-clock domain through a two-flop synchronizer. All later sampling happens only on cycles where the count-source enable strobe is high, so the block runs at the divided count-source rate while staying on a single clock.

With the filter off, the level is sampled once and registered once more, so it reaches the output two strobes after it is first captured. With the filter on, a new level is accepted only after the same level has been seen on four consecutive strobes. Otherwise the output keeps its previous value. Any change to the pin select, the invert bit or the filter enable clears the sampling pipeline and the output, and the stage then fills again from the new setting.

Top module: `rc_input_cond`

## Requirements
- R1: While reset is asserted and after it is released, `sigOut` is 0, and it stays 0 until a sampled level says otherwise.
- R2: `pinSel` picks `pinIn[pinSel]` as the channel input, and any pin index may be picked. Levels on the pins not picked have no effect on `sigOut`.
- R3: With `filterEn` = 0, a level held on the picked pin is captured on the first `csEn` strobe that sees it and appears on `sigOut` right after the second strobe. A level seen on only one strobe still passes.
- R4: With `filterEn` = 1, a new level appears on `sigOut` right after the fifth strobe that sees it. That is the strobe following four consecutive captures of the same level.
- R5: With `filterEn` = 1, a level that holds for fewer than four consecutive strobes never reaches `sigOut`.
- R6: On clock cycles where `csEn` is 0, `sigOut` does not change, whatever the pins do.
- R7: With `invertEn` = 1, the picked pin is logically inverted before capture, so a low pin drives `sigOut` to 1 and a high pin drives it to 0.
- R8: On the clock edge after any change of `pinSel`, `invertEn` or `filterEn`, the capture stage, the filter history and `sigOut` are all cleared to 0. Refilling then starts from the first later strobe. A clear takes priority over a strobe on the same cycle.
- R9: A pin change passes through two system-clock flops before sampling. A strobe on the second rising edge after the change still captures the old level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csEn | input | 1 | Count-source enable strobe, one system clock wide |
| pinIn | input | NUM_PINS | Raw external input pins |
| pinSel | input | SEL_W | Index of the pin that feeds this channel |
| invertEn | input | 1 | 1 inverts the picked pin level |
| filterEn | input | 1 | 1 enables the four-sample agreement filter |
| sigOut | output | 1 | Conditioned internal level |

## Verification
The bench counts strobes after each pin change and checks the exact strobe on which `sigOut` moves, both with and without the filter. A pipeline one stage too short or too long would show the edge one strobe early or late. A burst of three matching samples, followed by a return to the old level, checks the filter. A filter that compares only three samples would let that glitch through. Another check places a strobe on the second edge after a pin change, which exposes a synchronizer with only one flop. Other checks drive levels onto pins that are not picked, change the configuration while the output is high to confirm the clear, and hold the strobe low while the pin changes to catch any sampling that ignores the enable.

// File: rtl/rcin_pkg.sv
package rcin_pkg;

  // Strobes issued by the control side to the datapath each system clock.
  typedef struct packed {
    logic sample;  // advance the capture stage, history and output
    logic clear;   // flush capture stage, history and output to 0
  } rcinStrobeT;

endpackage

// File: rtl/rcin_sync.sv
module rcin_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : gBit
      logic stageA;
      logic stageB;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stageA <= 1'b0;
          stageB <= 1'b0;
        end else begin
          stageA <= asyncIn[gi];
          stageB <= stageA;
        end
      end
      assign syncOut[gi] = stageB;
    end
  endgenerate

endmodule

// File: rtl/rcin_ctrl.sv
module rcin_ctrl
  import rcin_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csEn,
  input  logic [SEL_W-1:0] pinSel,
  input  logic             invertEn,
  input  logic             filterEn,
  output rcinStrobeT       stb
);

  localparam int CFG_W = SEL_W + 2;

  logic [CFG_W-1:0] cfgNow;
  logic [CFG_W-1:0] cfgQ;
  logic             cfgChange;

  assign cfgNow    = {pinSel, invertEn, filterEn};
  assign cfgChange = (cfgNow != cfgQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else begin
      cfgQ <= cfgNow;
    end
  end

  // A configuration change flushes the stage and wins over a strobe.
  always_comb begin
    stb.clear  = cfgChange;
    stb.sample = csEn & ~cfgChange;
  end

  // R8: once the new setting has been registered, no clear is pending
  // unless the setting moved again.
  a_r8_clear_settles: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear && $stable(cfgNow) |=> !stb.clear);

endmodule

// File: rtl/rcin_datapath.sv
module rcin_datapath
  import rcin_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int SEL_W    = 2,
  parameter int FILT_LEN = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  rcinStrobeT          stb,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [SEL_W-1:0]    pinSel,
  input  logic                invertEn,
  input  logic                filterEn,
  output logic                sigOut
);

  localparam int HIST_W = FILT_LEN - 1;

  logic [NUM_PINS-1:0] pinSync;
  logic                pickedBit;
  logic                polBit;
  logic                stage1Q;
  logic [HIST_W-1:0]   histQ;
  logic [HIST_W-1:0]   histNext;
  logic [FILT_LEN-1:0] window;
  logic                allOne;
  logic                allZero;
  logic                filtNext;
  logic                outNext;

  rcin_sync #(.WIDTH(NUM_PINS)) uSync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(pinIn),
    .syncOut(pinSync)
  );

  assign pickedBit = pinSync[pinSel];
  assign polBit    = pickedBit ^ invertEn;

  // History shifts toward higher index; newest capture enters at 0.
  always_comb begin
    histNext[0] = stage1Q;
    for (int i = 1; i < HIST_W; i++) begin
      histNext[i] = histQ[i-1];
    end
  end

  assign window  = {histQ, stage1Q};
  assign allOne  = &window;
  assign allZero = ~|window;

  always_comb begin
    if (allOne) begin
      filtNext = 1'b1;
    end else if (allZero) begin
      filtNext = 1'b0;
    end else begin
      filtNext = sigOut;
    end
    outNext = filterEn ? filtNext : stage1Q;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Q <= 1'b0;
      histQ   <= '0;
      sigOut  <= 1'b0;
    end else if (stb.clear) begin
      stage1Q <= 1'b0;
      histQ   <= '0;
      sigOut  <= 1'b0;
    end else if (stb.sample) begin
      stage1Q <= polBit;
      histQ   <= histNext;
      sigOut  <= outNext;
    end
  end

  // R6: without a strobe or a clear the output holds.
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.sample && !stb.clear |=> $stable(sigOut));

  // R8: a clear empties the capture stage and the output.
  a_r8_flush: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> (sigOut == 1'b0) && (stage1Q == 1'b0) && (histQ == '0));

  // R3: unfiltered, the output takes the previously captured sample.
  a_r3_bypass: assert property (@(posedge clk) disable iff (!rstN)
    stb.sample && !filterEn |=> sigOut == $past(stage1Q));

  // R4: filtered, an output change is backed by agreeing history.
  a_r4_agree: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.sample) && $past(filterEn) && (sigOut != $past(sigOut))
    |-> histQ == {HIST_W{sigOut}});

endmodule

// File: rtl/rc_input_cond.sv
module rc_input_cond
  import rcin_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int SEL_W    = $clog2(NUM_PINS),
  parameter int FILT_LEN = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csEn,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [SEL_W-1:0]    pinSel,
  input  logic                invertEn,
  input  logic                filterEn,
  output logic                sigOut
);

  rcinStrobeT stb;

  rcin_ctrl #(.SEL_W(SEL_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .csEn    (csEn),
    .pinSel  (pinSel),
    .invertEn(invertEn),
    .filterEn(filterEn),
    .stb     (stb)
  );

  rcin_datapath #(
    .NUM_PINS(NUM_PINS),
    .SEL_W   (SEL_W),
    .FILT_LEN(FILT_LEN)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .pinIn   (pinIn),
    .pinSel  (pinSel),
    .invertEn(invertEn),
    .filterEn(filterEn),
    .sigOut  (sigOut)
  );

  // R1: the output is low while reset is held.
  always_comb begin
    if (!rstN) begin
      a_r1_reset_low: assert (sigOut == 1'b0);
    end
  end

endmodule

// File: tb/rc_input_cond_test.sv
module rc_input_cond_test;

  localparam int CLK_PERIOD = 10;
  localparam int NP         = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          csEn = 1'b0;
  logic [NP-1:0] pinIn = '0;
  logic [1:0]    pinSel = '0;
  logic          invertEn = 1'b0;
  logic          filterEn = 1'b0;
  logic          sigOut;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  rc_input_cond #(.NUM_PINS(NP), .FILT_LEN(4)) uut (
    .clk     (clk),
    .rstN    (rstN),
    .csEn    (csEn),
    .pinIn   (pinIn),
    .pinSel  (pinSel),
    .invertEn(invertEn),
    .filterEn(filterEn),
    .sigOut  (sigOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: sigOut=%b expected=%b", tag, act, exp);
    end
  endtask

  // One strobe, three clocks after the caller's negedge; returns at the
  // negedge right after the strobe edge.
  task automatic strobe();
    repeat (3) @(negedge clk);
    csEn = 1'b1;
    @(negedge clk);
    csEn = 1'b0;
  endtask

  task automatic setCfg(input logic [1:0] sel, input logic inv, input logic fil);
    @(negedge clk);
    pinSel = sel; invertEn = inv; filterEn = fil;
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R1 during reset", sigOut, 1'b0);
    @(negedge clk); rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after reset", sigOut, 1'b0);
  endtask

  task automatic testBypass();
    setCfg(2'd0, 1'b0, 1'b0);
    pinIn = 4'b0001;
    strobe(); check("R3 rise k1", sigOut, 1'b0);
    strobe(); check("R3 rise k2", sigOut, 1'b1);
    pinIn = 4'b0000;
    strobe(); check("R3 fall k1", sigOut, 1'b1);
    strobe(); check("R3 fall k2", sigOut, 1'b0);
    pinIn = 4'b0001;
    strobe();
    pinIn = 4'b0000;
    strobe(); check("R3 single-sample pulse passes", sigOut, 1'b1);
    strobe(); check("R3 single-sample pulse ends", sigOut, 1'b0);
  endtask

  task automatic testSync();
    setCfg(2'd0, 1'b0, 1'b0);
    pinIn = 4'b0001;
    @(negedge clk); csEn = 1'b1;
    @(negedge clk); csEn = 1'b0;
    strobe(); check("R9 early strobe missed", sigOut, 1'b0);
    strobe(); check("R9 level arrives", sigOut, 1'b1);
    pinIn = 4'b0000;
    strobe(); strobe();
  endtask

  task automatic testFilter();
    setCfg(2'd0, 1'b0, 1'b1);
    pinIn = 4'b0001;
    for (int k = 1; k <= 5; k++) begin
      strobe();
      check($sformatf("R4 rise k%0d", k), sigOut, (k == 5));
    end
    pinIn = 4'b0000;
    for (int k = 1; k <= 5; k++) begin
      strobe();
      check($sformatf("R4 fall k%0d", k), sigOut, (k < 5));
    end
  endtask

  task automatic testGlitch();
    setCfg(2'd0, 1'b0, 1'b1);
    pinIn = 4'b0001;
    repeat (3) strobe();
    pinIn = 4'b0000;
    for (int k = 1; k <= 6; k++) begin
      strobe();
      check($sformatf("R5 three-sample glitch k%0d", k), sigOut, 1'b0);
    end
  endtask

  task automatic testHold();
    setCfg(2'd0, 1'b0, 1'b0);
    pinIn = 4'b0001;
    repeat (30) @(negedge clk);
    check("R6 no strobe no change", sigOut, 1'b0);
    strobe(); strobe();
    check("R6 strobes resume", sigOut, 1'b1);
    pinIn = 4'b0000;
    repeat (30) @(negedge clk);
    check("R6 held high without strobe", sigOut, 1'b1);
  endtask

  task automatic testInvert();
    setCfg(2'd0, 1'b1, 1'b0);
    pinIn = 4'b0000;
    strobe(); strobe();
    check("R7 low pin gives 1", sigOut, 1'b1);
    pinIn = 4'b0001;
    strobe(); strobe();
    check("R7 high pin gives 0", sigOut, 1'b0);
  endtask

  task automatic testClear();
    setCfg(2'd0, 1'b0, 1'b0);
    pinIn = 4'b0001;
    strobe(); strobe();
    check("R8 precondition high", sigOut, 1'b1);
    setCfg(2'd0, 1'b0, 1'b1);
    check("R8 cleared on config change", sigOut, 1'b0);
    for (int k = 1; k <= 5; k++) begin
      strobe();
      check($sformatf("R8 refill k%0d", k), sigOut, (k == 5));
    end
  endtask

  task automatic testSelect();
    pinIn = 4'b0000;
    setCfg(2'd2, 1'b0, 1'b0);
    pinIn = 4'b1011;
    repeat (3) strobe();
    check("R2 unpicked pins ignored", sigOut, 1'b0);
    pinIn = 4'b0100;
    strobe(); strobe();
    check("R2 pin 2 picked", sigOut, 1'b1);
    setCfg(2'd1, 1'b0, 1'b0);
    pinIn = 4'b0010;
    strobe(); strobe();
    check("R2 neighbour pin 1 picked", sigOut, 1'b1);
    pinIn = 4'b1101;
    strobe(); strobe();
    check("R2 pin 1 low, others high", sigOut, 1'b0);
  endtask

  initial begin
    testReset();
    testBypass();
    testSync();
    testFilter();
    testGlitch();
    testHold();
    testInvert();
    testClear();
    testSelect();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule